// File: doc/BRIEF.md
# Reed-Solomon Packet Syndrome Checker

This block takes one code packet at a time over GF(2^10) and computes its eight syndromes as the symbols arrive. A packet holds 520 ten-bit symbols. The first 512 are data bytes, and each byte becomes a symbol by padding it with two zero bits at the top. The last 8 symbols are parity, and they arrive on their own 10-bit port.

The block counts the symbols it accepts. When the 520th symbol has been taken, it reports on its own whether any syndrome is nonzero. It does not wait for a command. The block does not locate or correct errors. It only flags a corrupted packet and exposes the syndromes, so that a separate corrector can use them.

A symbol offered on the port that does not match the packet position is dropped, and a sticky flag records the mistake. Driving `en` low aborts the packet in progress.

Top module: `rs_syn_check`

## Requirements
- R1: A data byte b is taken as the 10-bit symbol {2'b00, b}. The two upper bits of a data symbol never carry data.
- R2: Positions 0 to 511 of a packet accept only `dat_vld`, and positions 512 to 519 accept only `par_vld`. A strobe on the other port is discarded and sets `seq_err`. `seq_err` then stays at 1 until reset or until `en` goes low.
- R3: Symbol c_j at position j (j = 0..519) is the coefficient of x^(519-j). Syndrome S_i (i = 0..7) is the value of that polynomial at alpha^i, in GF(2^10) with the field polynomial x^10+x^3+1. S_i appears on `syn_flat[10*i+9:10*i]`.
- R4: The 520th symbol is accepted at clock edge k. `flag_vld` is still 0 after edge k and becomes 1 after edge k+1, with no other input needed.
- R5: While `flag_vld` is 1, `err_flag` is 1 exactly when at least one of the 520-symbol packet's syndromes is nonzero. `err_flag` is never 1 while `flag_vld` is 0.
- R6: Once `flag_vld` has risen, it and `err_flag` hold their values through idle cycles. Both clear at the edge that accepts the next symbol.
- R7: While `en` is 0, both strobes are ignored. The symbol position, all syndromes, `flag_vld`, `err_flag` and `seq_err` are cleared.
- R8: A synchronous active-high `rst` clears the position, the syndromes and all flags, including in the middle of a packet.
- R9: If both strobes are high in the same cycle, the port that matches the packet position is accepted normally. The other port is discarded and sets `seq_err` in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; low aborts and clears |
| dat_vld | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte |
| par_vld | input | 1 | Parity symbol strobe |
| par_sym | input | 10 | Parity symbol |
| err_flag | output | 1 | Packet has a nonzero syndrome |
| flag_vld | output | 1 | Qualifier for err_flag and syn_flat |
| seq_err | output | 1 | Sticky wrong-port indication |
| syn_flat | output | 80 | Eight 10-bit syndromes, S0 in the low bits |

## Verification
Two things can happen in the same edge: a symbol is accepted on the correct port while a strobe on the wrong port is rejected. The bench provokes this by raising `par_vld` in the same cycle as a data byte partway through the data phase. It also sends a lone data byte during the parity phase. It judges the result by requiring `seq_err` to rise while the final syndromes still equal the values computed for the clean packet, so neither stray symbol may leak into the arithmetic. Random codewords, generated by a systematic encoder in the bench and corrupted in random positions, are compared against syndromes computed by direct power evaluation.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int GF_W = 10;
  localparam logic [GF_W-1:0] GF_POLY = 10'h009; // x^10 + x^3 + 1, x^10 implicit

  // multiply by alpha
  function automatic logic [GF_W-1:0] gf_xtime(input logic [GF_W-1:0] a);
    return {a[GF_W-2:0], 1'b0} ^ (a[GF_W-1] ? GF_POLY : '0);
  endfunction

  function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                             input logic [GF_W-1:0] b);
    logic [GF_W-1:0] r;
    r = '0;
    for (int k = GF_W - 1; k >= 0; k--) begin
      r = gf_xtime(r);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [GF_W-1:0] gf_alpha_pow(input int e);
    logic [GF_W-1:0] r;
    r = '0;
    r[0] = 1'b1;
    for (int k = 0; k < e; k++) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
  import rs_syn_pkg::*;
#(
  parameter int DATA_N = 512,
  parameter int PAR_N  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              dat_vld,
  input  logic [BYTE_W-1:0] dat_byte,
  input  logic              par_vld,
  input  logic [GF_W-1:0]   par_sym,
  output logic              acc,
  output logic              first,
  output logic              last,
  output logic [GF_W-1:0]   sym,
  output logic              seq_err
);
  localparam int TOTAL = DATA_N + PAR_N;
  localparam int CNT_W = $clog2(TOTAL);

  logic [CNT_W-1:0] cnt;
  logic in_data, take_dat, take_par, wrong;

  always_comb begin
    in_data  = (cnt < CNT_W'(DATA_N));
    take_dat = en && dat_vld && in_data;
    take_par = en && par_vld && !in_data;
    wrong    = en && ((par_vld && in_data) || (dat_vld && !in_data));
    acc      = take_dat || take_par;
    first    = (cnt == '0);
    last     = (cnt == CNT_W'(TOTAL - 1));
    sym      = in_data ? {{(GF_W-BYTE_W){1'b0}}, dat_byte} : par_sym;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      seq_err <= 1'b0;
    end else begin
      if (acc) cnt <= last ? '0 : cnt + 1'b1;
      if (wrong) seq_err <= 1'b1;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(TOTAL));
  p_seq_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_err && en) |=> seq_err);
  p_both_strobes_r9: assert property (@(posedge clk) disable iff (rst)
    (en && dat_vld && par_vld) |=> seq_err);
endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            acc_en,
  input  logic            first,
  input  logic [GF_W-1:0] sym,
  output logic [GF_W-1:0] syn
);
  localparam logic [GF_W-1:0] ROOT = gf_alpha_pow(IDX);

  // Horner step: S <= S * alpha^IDX + symbol, restart on first symbol
  always_ff @(posedge clk) begin
    if (rst || clr) syn <= '0;
    else if (acc_en) syn <= (first ? '0 : gf_mul(syn, ROOT)) ^ sym;
  end

  p_first_load_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && first && !clr) |=> (syn == $past(sym)));
endmodule

// File: rtl/rs_syn_check.sv
module rs_syn_check
  import rs_syn_pkg::*;
#(
  parameter int DATA_N = 512,
  parameter int PAR_N  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  dat_vld,
  input  logic [BYTE_W-1:0]     dat_byte,
  input  logic                  par_vld,
  input  logic [GF_W-1:0]       par_sym,
  output logic                  err_flag,
  output logic                  flag_vld,
  output logic                  seq_err,
  output logic [PAR_N*GF_W-1:0] syn_flat
);
  localparam int NSYN = PAR_N;

  logic            acc, first, last, last_q;
  logic [GF_W-1:0] sym;

  rs_seq_ctrl #(.DATA_N(DATA_N), .PAR_N(PAR_N), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .dat_vld(dat_vld), .dat_byte(dat_byte),
    .par_vld(par_vld), .par_sym(par_sym),
    .acc(acc), .first(first), .last(last), .sym(sym), .seq_err(seq_err)
  );

  for (genvar i = 0; i < NSYN; i++) begin : g_syn
    rs_syn_cell #(.IDX(i)) u_cell (
      .clk(clk), .rst(rst), .clr(!en), .acc_en(acc), .first(first),
      .sym(sym), .syn(syn_flat[i*GF_W +: GF_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      last_q   <= 1'b0;
      flag_vld <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      last_q <= acc && last;
      if (last_q) begin
        flag_vld <= 1'b1;
        err_flag <= |syn_flat;
      end else if (acc && flag_vld) begin
        flag_vld <= 1'b0;
        err_flag <= 1'b0;
      end
    end
  end

  p_valid_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && last && en) ##1 en |=> flag_vld);
  p_err_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> flag_vld);
  p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!flag_vld && !seq_err && syn_flat == '0));
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_vld && en && !dat_vld && !par_vld) |=> (flag_vld && $stable(err_flag)));
endmodule

// File: tb/rs_syn_check_tb.sv
module rs_syn_check_tb;
  localparam logic [9:0] POLY = 10'h009;
  localparam int NTOT = 520;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic dat_vld = 1'b0, par_vld = 1'b0;
  logic [7:0] dat_byte = '0;
  logic [9:0] par_sym = '0;
  logic err_flag, flag_vld, seq_err;
  logic [79:0] syn_flat;

  always #5 clk = ~clk;

  rs_syn_check u_dut (
    .clk(clk), .rst(rst), .en(en), .dat_vld(dat_vld), .dat_byte(dat_byte),
    .par_vld(par_vld), .par_sym(par_sym), .err_flag(err_flag),
    .flag_vld(flag_vld), .seq_err(seq_err), .syn_flat(syn_flat)
  );

  int nchk = 0, nfail = 0;
  logic [9:0] apow [1023];
  logic [9:0] gen [9];
  logic [7:0] msg [512];
  logic [9:0] par [8];

  // LSB-first shift-and-add multiply
  function automatic logic [9:0] fmul(input logic [9:0] a, input logic [9:0] b);
    logic [9:0] r, x;
    r = '0; x = a;
    for (int k = 0; k < 10; k++) begin
      if (b[k]) r ^= x;
      x = x[9] ? ({x[8:0], 1'b0} ^ POLY) : {x[8:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [9:0] csym(input int j);
    return (j < 512) ? {2'b00, msg[j]} : par[j-512];
  endfunction

  function automatic logic [79:0] exp_syn();
    logic [79:0] s;
    s = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < NTOT; j++)
        s[i*10 +: 10] ^= fmul(csym(j), apow[(i * (NTOT - 1 - j)) % 1023]);
    return s;
  endfunction

  task automatic encode();
    logic [9:0] rem [8];
    logic [9:0] fb;
    for (int k = 0; k < 8; k++) rem[k] = '0;
    for (int j = 0; j < 512; j++) begin
      fb = {2'b00, msg[j]} ^ rem[7];
      for (int k = 7; k > 0; k--) rem[k] = rem[k-1] ^ fmul(fb, gen[k]);
      rem[0] = fmul(fb, gen[0]);
    end
    for (int k = 0; k < 8; k++) par[k] = rem[7-k];
  endtask

  task automatic rand_msg();
    for (int j = 0; j < 512; j++) msg[j] = 8'($urandom);
  endtask

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_packet(input int inj_par_at, input int inj_dat_at);
    for (int j = 0; j < NTOT; j++) begin
      if (($urandom % 4) == 0) idle($urandom % 3);
      if (j >= 512 && (j - 512) == inj_dat_at) begin
        dat_vld = 1'b1; dat_byte = 8'($urandom);
        @(negedge clk); dat_vld = 1'b0;
      end
      if (j < 512) begin
        dat_vld = 1'b1; dat_byte = msg[j];
        if (j == inj_par_at) begin par_vld = 1'b1; par_sym = 10'($urandom); end
      end else begin
        par_vld = 1'b1; par_sym = par[j-512];
      end
      @(negedge clk);
      dat_vld = 1'b0; par_vld = 1'b0;
    end
  endtask

  task automatic check_result(input string tag);
    logic [79:0] e;
    e = exp_syn();
    chk({"R4 not early ", tag}, 80'(flag_vld), 80'd0);
    @(negedge clk);
    chk({"R4 valid ", tag}, 80'(flag_vld), 80'd1);
    chk({"R3 syndromes ", tag}, syn_flat, e);
    chk({"R5 err ", tag}, 80'(err_flag), 80'(e != '0));
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
    $finish;
  end

  initial begin
    logic [9:0] ng [9];
    void'($urandom(32'h5eed_1234));
    apow[0] = 10'd1;
    for (int k = 1; k < 1023; k++) apow[k] = fmul(apow[k-1], 10'd2);
    for (int k = 0; k < 9; k++) gen[k] = '0;
    gen[0] = 10'd1;
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 9; k++) ng[k] = '0;
      for (int k = 0; k < 8; k++) begin
        ng[k+1] ^= gen[k];
        ng[k]   ^= fmul(gen[k], apow[i]);
      end
      for (int k = 0; k < 9; k++) gen[k] = ng[k];
    end

    idle(3);
    // R8 reset state
    chk("R8 flag_vld", 80'(flag_vld), 80'd0);
    chk("R8 err_flag", 80'(err_flag), 80'd0);
    chk("R8 seq_err", 80'(seq_err), 80'd0);
    chk("R8 syn", syn_flat, 80'd0);
    rst = 1'b0; en = 1'b1;
    idle(1);

    // clean codeword
    rand_msg(); msg[0] = 8'hFF; msg[511] = 8'hFF; encode();
    send_packet(-1, -1);
    check_result("clean");
    chk("R5 clean err zero", 80'(err_flag), 80'd0);
    chk("R2 no seq_err", 80'(seq_err), 80'd0);

    // R1: corrupt a byte of value FF; padding must stay zero
    msg[0] = 8'h7F;
    send_packet(-1, -1);
    check_result("R1 widen");

    // R6 hold through idle, clear on next accepted symbol
    idle(5);
    chk("R6 hold", 80'(flag_vld), 80'd1);
    chk("R6 hold err", 80'(err_flag), 80'd1);
    dat_vld = 1'b1; dat_byte = 8'h12; @(negedge clk); dat_vld = 1'b0;
    chk("R6 cleared", 80'({flag_vld, err_flag}), 80'd0);

    // R2 parity during data phase
    par_vld = 1'b1; par_sym = 10'h155; @(negedge clk); par_vld = 1'b0;
    chk("R2 seq_err set", 80'(seq_err), 80'd1);

    // R7 disable clears, strobes ignored
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      dat_vld = 1'b1; par_vld = 1'b1; dat_byte = 8'($urandom); @(negedge clk);
    end
    dat_vld = 1'b0; par_vld = 1'b0;
    chk("R7 syn cleared", syn_flat, 80'd0);
    chk("R7 flags cleared", 80'({seq_err, flag_vld, err_flag}), 80'd0);
    en = 1'b1;

    // R9 both strobes together in data phase, R2 stray data in parity phase
    rand_msg(); encode();
    send_packet(100, 3);
    check_result("R9 concurrent");
    chk("R9 seq_err", 80'(seq_err), 80'd1);

    // R8 reset mid-packet
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R8 mid seq_err", 80'(seq_err), 80'd0);
    rand_msg(); encode();
    for (int j = 0; j < 50; j++) begin
      dat_vld = 1'b1; dat_byte = msg[j]; @(negedge clk);
    end
    dat_vld = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R8 mid syn", syn_flat, 80'd0);
    msg[7] = msg[7] ^ 8'h01;
    send_packet(-1, -1);
    check_result("R8 after reset");

    // random packets with 0..4 corrupted symbols
    for (int t = 0; t < 4; t++) begin
      rand_msg(); encode();
      for (int e = 0; e < int'($urandom % 5); e++) begin
        if (($urandom % 2) == 0) msg[$urandom % 512] ^= 8'($urandom | 1);
        else par[$urandom % 8] ^= 10'($urandom | 1);
      end
      send_packet(-1, -1);
      check_result("R3 random");
      idle(2);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule